// File: doc/BRIEF.md
# Xoroshiro32 Pseudo-Random Generator with Parity Output

This block holds a 32-bit generator state, split into a low half and a high half, and advances it with a xorshift/rotate step that uses the fixed shift triplet [15,3,6]. Each 16-bit result comes from the 17-bit sum of the two halves. The top fifteen bits of the sum are kept, and bit 0 is replaced by the parity of the whole 17-bit sum.

A client pulses a request strobe and gives a mode bit with it. In single mode the state moves forward one step and one 16-bit value is returned. In double mode the state moves forward two steps and two values are packed into one 32-bit word. A seed port writes the state directly. The result is registered and carries a one-cycle valid flag. A status flag warns when the all-zero state, which never leaves itself, has been loaded.

Top module: `xr_gen`

## Requirements
- R1: One step, with lo = state[15:0] and hi = state[31:16], computes t = lo ^ hi. The new hi is t rotated left by 6. The new lo is (lo rotated left by 15) ^ t ^ (t << 3).
- R2: A 16-bit output word is built from a state as follows. Take s = lo + hi as a 17-bit value. The word is s[15:1] in bits 15..1 and the XOR of all 17 bits of s in bit 0.
- R3: A double request steps the state twice. Bits 15..0 of the result hold the output word of the state after the first step. Bits 31..16 hold the output word of the state after the second step.
- R4: After reset, four double requests return 32'h54658048, 32'h51BE8BA2, 32'h35E3784F and 32'h AFD08E7D in that order.
- R5: A single request steps the state once. It returns the output word of the new state in bits 15..0, with bits 31..16 at zero.
- R6: The result valid flag is high in the cycle after each accepted request and low in every other cycle.
- R7: A seed write loads the state from the seed port. In the same cycle it overrides any request, so the valid flag is low in the next cycle.
- R8: Writing a zero seed is accepted and raises the stuck flag. The zero state returns all-zero results. A nonzero seed write lowers the flag. The flag changes only on a seed write.
- R9: Reset sets the state to 32'h00000001 and clears the result, the valid flag and the stuck flag.
- R10: Single and double requests can be mixed freely. Each request continues from the state that the previous one left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_we | input | 1 | Load the state from seed_val |
| seed_val | input | 32 | Seed value, high half in bits 31..16 |
| req | input | 1 | Request strobe |
| req_dbl | input | 1 | 1 = double step, 0 = single step |
| rslt | output | 32 | Registered result word |
| rslt_vld | output | 1 | Result valid, one cycle per request |
| stuck | output | 1 | State was seeded with zero |

## Verification
Any error in the state shows up in the result word of the very next request, because every output word is computed from the state just stepped. Errors then carry forward in every later word of that sequence. A wrong parity bit or a wrong sum tap shows up at once in bit 0 or in the upper bits. A wrong packing order shows up as swapped halves on the first double request. Running long mixed sequences from many seeds, plus the four known reset-seed values, ties the step function itself to a fixed reference.

// File: rtl/xr_pkg.sv
package xr_pkg;

    localparam int XR_HALF_W   = 16;
    localparam int XR_ROT_LO   = 15;
    localparam int XR_SHL_T    = 3;
    localparam int XR_ROT_HI   = 6;
    localparam int XR_MAX_STEP = 2;

    typedef enum logic {
        XR_SINGLE = 1'b0,
        XR_DOUBLE = 1'b1
    } xr_mode_e;

endpackage

// File: rtl/xr_step.sv
module xr_step #(
    parameter int HW    = xr_pkg::XR_HALF_W,
    parameter int ROT_L = xr_pkg::XR_ROT_LO,
    parameter int SHL_T = xr_pkg::XR_SHL_T,
    parameter int ROT_H = xr_pkg::XR_ROT_HI
) (
    input  logic [2*HW-1:0] st_i,
    output logic [2*HW-1:0] st_o
);
    typedef struct packed {
        logic [HW-1:0] hi;
        logic [HW-1:0] lo;
    } halves_t;

    halves_t       cur;
    halves_t       nxt;
    logic [HW-1:0] mix;

    function automatic logic [HW-1:0] rotl(input logic [HW-1:0] x, input int r);
        logic [2*HW-1:0] dbl;
        dbl = {x, x} << r;
        return dbl[2*HW-1:HW];
    endfunction

    always_comb begin
        cur    = halves_t'(st_i);
        mix    = cur.lo ^ cur.hi;
        nxt.hi = rotl(mix, ROT_H);
        nxt.lo = rotl(cur.lo, ROT_L) ^ mix ^ (mix << SHL_T);
        st_o   = nxt;
    end
endmodule

// File: rtl/xr_fold.sv
module xr_fold #(
    parameter int HW = xr_pkg::XR_HALF_W
) (
    input  logic [2*HW-1:0] st_i,
    output logic [HW-1:0]   word_o
);
    logic [HW:0] total;

    always_comb begin
        total  = {1'b0, st_i[2*HW-1:HW]} + {1'b0, st_i[HW-1:0]};
        word_o = {total[HW-1:1], ^total};
    end
endmodule

// File: rtl/xr_gen.sv
module xr_gen #(
    parameter int          HW         = xr_pkg::XR_HALF_W,
    parameter logic [31:0] RESET_SEED = 32'h0000_0001
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seed_we,
    input  logic [2*HW-1:0] seed_val,
    input  logic          req,
    input  logic          req_dbl,
    output logic [2*HW-1:0] rslt,
    output logic          rslt_vld,
    output logic          stuck
);
    import xr_pkg::*;

    localparam int SW    = 2 * HW;
    localparam int NSTEP = XR_MAX_STEP;

    logic [SW-1:0] state_q;
    logic [SW-1:0] chain [NSTEP+1];
    logic [HW-1:0] word  [1:NSTEP];
    xr_mode_e      mode;

    assign chain[0] = state_q;
    assign mode     = xr_mode_e'(req_dbl);

    for (genvar g = 1; g <= NSTEP; g++) begin : g_stage
        xr_step #(.HW(HW)) u_step (
            .st_i (chain[g-1]),
            .st_o (chain[g])
        );
        xr_fold #(.HW(HW)) u_fold (
            .st_i   (chain[g]),
            .word_o (word[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SW'(RESET_SEED);
            rslt     <= '0;
            rslt_vld <= 1'b0;
            stuck    <= 1'b0;
        end else if (seed_we) begin
            state_q  <= seed_val;
            rslt_vld <= 1'b0;
            stuck    <= (seed_val == '0);
        end else if (req) begin
            rslt_vld <= 1'b1;
            if (mode == XR_DOUBLE) begin
                state_q <= chain[2];
                rslt    <= {word[2], word[1]};
            end else begin
                state_q <= chain[1];
                rslt    <= {{HW{1'b0}}, word[1]};
            end
        end else begin
            rslt_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/xr_gen_chk.sv
module xr_gen_chk #(
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          seed_we,
    input logic [2*HW-1:0] seed_val,
    input logic          req,
    input logic          req_dbl,
    input logic [2*HW-1:0] rslt,
    input logic          rslt_vld,
    input logic          stuck
);
    assert_vld_after_req_R6: assert property (@(posedge clk) disable iff (rst)
        (req && !seed_we) |=> rslt_vld);

    assert_vld_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!req && !seed_we) |=> !rslt_vld);

    assert_seed_wins_R7: assert property (@(posedge clk) disable iff (rst)
        seed_we |=> !rslt_vld);

    assert_single_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (req && !req_dbl && !seed_we) |=> (rslt[2*HW-1:HW] == '0));

    assert_zero_seed_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (seed_we && seed_val == '0) |=> stuck);

    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !seed_we |=> $stable(stuck));
endmodule

bind xr_gen xr_gen_chk #(.HW(HW)) u_xr_gen_chk (
    .clk      (clk),
    .rst      (rst),
    .seed_we  (seed_we),
    .seed_val (seed_val),
    .req      (req),
    .req_dbl  (req_dbl),
    .rslt     (rslt),
    .rslt_vld (rslt_vld),
    .stuck    (stuck)
);

// File: tb/test_xr_gen.sv
`timescale 1ns/1ps
module test_xr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        seed_we;
    logic [31:0] seed_val;
    logic        req;
    logic        req_dbl;
    logic [31:0] rslt;
    logic        rslt_vld;
    logic        stuck;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] m_state;

    always #2.5 clk = ~clk;

    xr_gen i_xr_gen (
        .clk(clk), .rst(rst), .seed_we(seed_we), .seed_val(seed_val),
        .req(req), .req_dbl(req_dbl), .rslt(rslt), .rslt_vld(rslt_vld), .stuck(stuck)
    );

    function automatic logic [31:0] m_step(input logic [31:0] s);
        logic [15:0] a, b, t, nh, nl;
        a  = s[15:0];
        b  = s[31:16];
        t  = a ^ b;
        nh = 16'((t << 6) | (t >> 10));
        nl = 16'((a << 15) | (a >> 1)) ^ t ^ 16'(t << 3);
        return {nh, nl};
    endfunction

    function automatic logic [15:0] m_word(input logic [31:0] s);
        logic [16:0] sm;
        logic        p;
        sm = 17'(s[15:0]) + 17'(s[31:16]);
        p  = 1'b0;
        for (int i = 0; i < 17; i++) p = p ^ sm[i];
        return {sm[15:1], p};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic dbl, input string tag);
        logic [31:0] s1, s2, exp;
        s1 = m_step(m_state);
        s2 = m_step(s1);
        if (dbl) begin
            exp = {m_word(s2), m_word(s1)};
            m_state = s2;
        end else begin
            exp = {16'h0, m_word(s1)};
            m_state = s1;
        end
        req = 1'b1; req_dbl = dbl;
        @(negedge clk);
        req = 1'b0;
        check(tag, rslt, exp);
        check("R6 valid after request", {31'h0, rslt_vld}, 32'h1);
    endtask

    task automatic do_seed(input logic [31:0] s);
        seed_we = 1'b1; seed_val = s;
        @(negedge clk);
        seed_we = 1'b0;
        m_state = s;
    endtask

    initial begin
        rst = 1'b1; seed_we = 1'b0; seed_val = '0; req = 1'b0; req_dbl = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 result after reset", rslt, 32'h0);
        check("R9 valid after reset", {31'h0, rslt_vld}, 32'h0);
        check("R9 stuck after reset", {31'h0, stuck}, 32'h0);
        // R4 known sequence from the reset seed (also R9 state = 1)
        m_state = 32'h1;
        do_req(1'b1, "R4 first");
        check("R4 word0", rslt, 32'h54658048);
        do_req(1'b1, "R4 second");
        check("R4 word1", rslt, 32'h51BE8BA2);
        do_req(1'b1, "R4 third");
        check("R4 word2", rslt, 32'h35E3784F);
        do_req(1'b1, "R4 fourth");
        check("R4 word3", rslt, 32'hAFD08E7D);
        @(negedge clk);
        check("R6 valid low when idle", {31'h0, rslt_vld}, 32'h0);

        // R1 R2 R3 R5 R10: seed sweep with mixed modes
        for (int k = 0; k < 64; k++) begin
            logic [31:0] sd;
            logic [7:0]  pat;
            sd  = 32'(k) * 32'h9E3779B9 + 32'h0000_1234;
            pat = 8'(k * 37 + 5);
            do_seed(sd);
            check("R7 valid low after seed", {31'h0, rslt_vld}, 32'h0);
            for (int j = 0; j < 8; j++) begin
                do_req(pat[j], pat[j] ? "R3 double R1 R2 R10" : "R5 single R1 R2 R10");
                if (j == 3) begin
                    @(negedge clk);
                    check("R6 valid low in gap", {31'h0, rslt_vld}, 32'h0);
                end
            end
        end

        // R7 seed and request in the same cycle
        seed_we = 1'b1; seed_val = 32'hCAFE_0101; req = 1'b1; req_dbl = 1'b1;
        @(negedge clk);
        seed_we = 1'b0; req = 1'b0;
        m_state = 32'hCAFE_0101;
        check("R7 seed overrides request", {31'h0, rslt_vld}, 32'h0);
        do_req(1'b1, "R7 state taken from seed");

        // R8 zero seed
        do_seed(32'h0);
        check("R8 stuck raised", {31'h0, stuck}, 32'h1);
        do_req(1'b1, "R8 zero state double");
        check("R8 zero output", rslt, 32'h0);
        do_req(1'b0, "R8 zero state single");
        check("R8 stuck held", {31'h0, stuck}, 32'h1);
        do_seed(32'h0000_0001);
        check("R8 stuck cleared", {31'h0, stuck}, 32'h0);
        do_req(1'b1, "R8 R4 restart");
        check("R8 restart value", rslt, 32'h54658048);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule